// File: doc/BRIEF.md
# Cyclic Passing Phase Window Selector

A tuning sweep tries every sampling phase of a receive delay line and records which ones read the test pattern correctly. This block takes that record and returns the single phase the receiver should use. The record arrives in one of two forms. It can be a pass mask, where bit i set means phase i passed. It can also be a stream of passing phase indices in ascending order, one per valid cycle, closed by an end marker.

The block splits the passing phases into runs of consecutive indices. The phase space is circular. So when the first run starts at phase 0 and the final run ends at the top phase, the two runs form one window: the final run comes first and the phase-0 run continues it. The block keeps the longest window and walks three quarters of the way into it. It then reports that phase, or an error flag when no valid choice exists.

A job begins with a one-cycle `start` while the block is idle. The answer appears with a one-cycle `done` pulse.

Top module: `phase_window_sel`

## Requirements
- R1: An empty list produces `err`=1 with `done`, and `phase` reads 0 on any cycle where `err` is 1.
- R2: In stream mode, a list of more than NUM_PHASES entries produces `err`=1.
- R3: A new run begins whenever a passing phase is not exactly one more than the previous one. Phase NUM_PHASES-1 followed by phase 0 is not consecutive.
- R4: The two runs are joined into one window when both of these hold: the first run starts at phase 0, and a later run ends at phase NUM_PHASES-1. The window starts at the later run's first phase, and its length is the sum of the two run lengths. A joined length of NUM_PHASES or more is an error.
- R5: The longest window is selected. When lengths are equal, the window that comes earlier in scan order wins. A joined window is ranked at the position of its later run.
- R6: The offset into the chosen window is floor(3·L/4), less one when that value is nonzero. The result is (window start + offset) modulo NUM_PHASES.
- R7: When every phase passes, the result is phase 11 (for 16 phases) and `err` is 0.
- R8: `done` is high for exactly one cycle per job. `err` and `phase` are valid on that cycle. `err` is never high without `done`.
- R9: `use_mask`=1 at `start` selects the mask form (bit i = phase i passes). Otherwise the stream form is used: entries count only while the block is busy, and `item_last` ends the list, whether or not `item_valid` is high on the same cycle.
- R10: After reset, `done`, `err` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (taken while idle) |
| use_mask | input | 1 | 1: mask form, 0: stream form |
| pass_mask | input | NUM_PHASES | Pass mask, sampled at start |
| item_valid | input | 1 | Stream entry valid |
| item_phase | input | PW | Stream entry phase index |
| item_last | input | 1 | Marks end of the stream list |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | No valid phase (with done) |
| phase | output | PW | Selected phase (with done) |

## Verification
The assertions watch the handshake on every cycle. They check that `done` is a single-cycle strobe that closes a busy period. They also check that `err` never appears without `done`, that an error forces phase 0, that `start` while idle raises `busy`, and that the block is quiet after reset. Whether the chosen phase is right can only be shown by the bench's scenarios. These cover run splitting, the wrap-around join and its ranking against an equal-length middle run, the three-quarter offset, overlong and empty lists, and random masks fed in both forms against an independent model.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MASK,
        ST_STREAM,
        ST_FINAL
    } pws_state_e;

    // Three-quarter index into a window of the given length, minus one if nonzero.
    function automatic logic [15:0] tq_offset(input logic [15:0] len);
        logic [17:0] p;
        p = ({2'b00, len} * 18'd3) >> 2;
        if (p != 18'd0)
            p = p - 18'd1;
        return p[15:0];
    endfunction

endpackage

// File: rtl/pws_run_tracker.sv
module pws_run_tracker #(
    parameter int NPH = 16,
    parameter int PW  = 4,
    parameter int CW  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          ent_v,
    input  logic [PW-1:0] ent_p,
    output logic [CW-1:0] cnt,
    output logic [PW-1:0] prev,
    output logic          multi,
    output logic [PW-1:0] cur_start,
    output logic [CW-1:0] cur_len,
    output logic [PW-1:0] r0_start,
    output logic [CW-1:0] r0_len,
    output logic [PW-1:0] mid_start,
    output logic [CW-1:0] mid_len
);
    logic have;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt       <= '0;
            prev      <= '0;
            have      <= 1'b0;
            multi     <= 1'b0;
            cur_start <= '0;
            cur_len   <= '0;
            r0_start  <= '0;
            r0_len    <= '0;
            mid_start <= '0;
            mid_len   <= '0;
        end else if (ent_v) begin
            if (cnt <= CW'(NPH))
                cnt <= cnt + CW'(1);
            if (cnt < CW'(NPH)) begin
                prev <= ent_p;
                if (!have) begin
                    have      <= 1'b1;
                    cur_start <= ent_p;
                    cur_len   <= CW'(1);
                end else if ({1'b0, ent_p} == ({1'b0, prev} + (PW+1)'(1))) begin
                    cur_len <= cur_len + CW'(1);
                end else begin
                    // close the current run
                    if (!multi) begin
                        r0_start <= cur_start;
                        r0_len   <= cur_len;
                    end else if (cur_len > mid_len) begin
                        mid_start <= cur_start;
                        mid_len   <= cur_len;
                    end
                    multi     <= 1'b1;
                    cur_start <= ent_p;
                    cur_len   <= CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pws_window_pick.sv
module pws_window_pick
    import pws_pkg::*;
#(
    parameter int NPH = 16,
    parameter int PW  = 4,
    parameter int CW  = 5
) (
    input  logic [CW-1:0] cnt,
    input  logic [PW-1:0] prev,
    input  logic          multi,
    input  logic [PW-1:0] cur_start,
    input  logic [CW-1:0] cur_len,
    input  logic [PW-1:0] r0_start,
    input  logic [CW-1:0] r0_len,
    input  logic [PW-1:0] mid_start,
    input  logic [CW-1:0] mid_len,
    output logic [PW-1:0] sel_phase,
    output logic          sel_err
);
    localparam int LW = CW + 1;

    logic          merged;
    logic [LW-1:0] eff_len;
    logic [LW-1:0] b_len;
    logic [PW-1:0] b_start;
    logic [15:0]   off;

    always_comb begin
        merged  = multi && (r0_start == '0) && (prev == PW'(NPH - 1));
        eff_len = {1'b0, cur_len} + (merged ? {1'b0, r0_len} : LW'(0));
        if (!multi) begin
            b_start = cur_start;
            b_len   = {1'b0, cur_len};
        end else begin
            // scan order: first run, middle runs, final run
            b_start = merged ? '0 : r0_start;
            b_len   = merged ? '0 : {1'b0, r0_len};
            if ({1'b0, mid_len} > b_len) begin
                b_start = mid_start;
                b_len   = {1'b0, mid_len};
            end
            if (eff_len > b_len) begin
                b_start = cur_start;
                b_len   = eff_len;
            end
        end
        off       = tq_offset(16'(b_len));
        sel_phase = b_start + off[PW-1:0];
        sel_err   = (cnt == '0) || (cnt > CW'(NPH))
                  || (merged && (eff_len >= LW'(NPH)));
    end

endmodule

// File: rtl/phase_window_sel.sv
module phase_window_sel
    import pws_pkg::*;
#(
    parameter int NUM_PHASES = 16,
    localparam int PW = $clog2(NUM_PHASES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  use_mask,
    input  logic [NUM_PHASES-1:0] pass_mask,
    input  logic                  item_valid,
    input  logic [PW-1:0]         item_phase,
    input  logic                  item_last,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic [PW-1:0]         phase
);
    localparam int CW = PW + 1;

    pws_state_e            state;
    logic [NUM_PHASES-1:0] mask_q;
    logic [PW-1:0]         idx;
    logic                  ent_v;
    logic [PW-1:0]         ent_p;
    logic                  clr;

    logic [CW-1:0] t_cnt, t_cur_len, t_r0_len, t_mid_len;
    logic [PW-1:0] t_prev, t_cur_start, t_r0_start, t_mid_start;
    logic          t_multi;
    logic [PW-1:0] sel_phase;
    logic          sel_err;

    always_comb begin
        ent_v = 1'b0;
        ent_p = '0;
        case (state)
            ST_MASK: begin
                ent_v = mask_q[idx];
                ent_p = idx;
            end
            ST_STREAM: begin
                ent_v = item_valid;
                ent_p = item_phase;
            end
            default: ;
        endcase
    end

    assign clr  = (state == ST_IDLE) && start;
    assign busy = (state != ST_IDLE);

    pws_run_tracker #(.NPH(NUM_PHASES), .PW(PW), .CW(CW)) u_track (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .ent_v     (ent_v),
        .ent_p     (ent_p),
        .cnt       (t_cnt),
        .prev      (t_prev),
        .multi     (t_multi),
        .cur_start (t_cur_start),
        .cur_len   (t_cur_len),
        .r0_start  (t_r0_start),
        .r0_len    (t_r0_len),
        .mid_start (t_mid_start),
        .mid_len   (t_mid_len)
    );

    pws_window_pick #(.NPH(NUM_PHASES), .PW(PW), .CW(CW)) u_pick (
        .cnt       (t_cnt),
        .prev      (t_prev),
        .multi     (t_multi),
        .cur_start (t_cur_start),
        .cur_len   (t_cur_len),
        .r0_start  (t_r0_start),
        .r0_len    (t_r0_len),
        .mid_start (t_mid_start),
        .mid_len   (t_mid_len),
        .sel_phase (sel_phase),
        .sel_err   (sel_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mask_q <= '0;
            idx    <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            phase  <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mask_q <= pass_mask;
                        idx    <= '0;
                        state  <= use_mask ? ST_MASK : ST_STREAM;
                    end
                end
                ST_MASK: begin
                    idx <= idx + PW'(1);
                    if (idx == PW'(NUM_PHASES - 1))
                        state <= ST_FINAL;
                end
                ST_STREAM: begin
                    if (item_last)
                        state <= ST_FINAL;
                end
                default: begin
                    done  <= 1'b1;
                    err   <= sel_err;
                    phase <= sel_err ? '0 : sel_phase;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/phase_window_sel_chk.sv
module phase_window_sel_chk #(
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [PW-1:0] phase
);
    p_err_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    p_phase_zero_on_err_r1: assert property (@(posedge clk) disable iff (rst)
        err |-> (phase == '0));

    p_start_sets_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !err && !busy));
endmodule

bind phase_window_sel phase_window_sel_chk #(.PW(PW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .err   (err),
    .phase (phase)
);

// File: tb/phase_window_sel_test.sv
`timescale 1ns/1ps
module phase_window_sel_test;
    localparam int NP = 16;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          use_mask = 1'b0;
    logic [NP-1:0] pass_mask = '0;
    logic          item_valid = 1'b0;
    logic [PW-1:0] item_phase = '0;
    logic          item_last = 1'b0;
    logic          busy, done, err;
    logic [PW-1:0] phase;

    int ncomp = 0;
    int nfail = 0;

    typedef struct {
        bit    e;
        int    ph;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    phase_window_sel #(.NUM_PHASES(NP)) uut (
        .clk(clk), .rst(rst), .start(start), .use_mask(use_mask),
        .pass_mask(pass_mask), .item_valid(item_valid), .item_phase(item_phase),
        .item_last(item_last), .busy(busy), .done(done), .err(err), .phase(phase)
    );

    // Independent model of the selection rules (R1..R7)
    function automatic void ref_model(input int lst[$], output bit e, output int ph);
        int st[NP];
        int ln[NP];
        int r, bl, bs, o;
        e = 1'b0;
        ph = 0;
        if (lst.size() == 0 || lst.size() > NP) begin
            e = 1'b1;
            return;
        end
        r = 0;
        st[0] = lst[0];
        ln[0] = 1;
        for (int i = 1; i < lst.size(); i++) begin
            if (lst[i] == lst[i-1] + 1) ln[r]++;
            else begin
                r++;
                st[r] = lst[i];
                ln[r] = 1;
            end
        end
        if (r > 0 && st[0] == 0 && st[r] + ln[r] - 1 == NP - 1) begin
            ln[r] += ln[0];
            ln[0] = 0;
            if (ln[r] >= NP) begin
                e = 1'b1;
                return;
            end
        end
        bl = 0;
        bs = 0;
        for (int k = 0; k <= r; k++)
            if (ln[k] > bl) begin
                bl = ln[k];
                bs = st[k];
            end
        o = (bl * 3) / 4;
        if (o > 0) o--;
        ph = (bs + o) % NP;
    endfunction

    function automatic void mask_list(input logic [NP-1:0] m, output int lst[$]);
        lst = {};
        for (int i = 0; i < NP; i++)
            if (m[i]) lst.push_back(i);
    endfunction

    task automatic push_exp(input int lst[$], input string tag);
        exp_t x;
        ref_model(lst, x.e, x.ph);
        x.tag = tag;
        sb.push_back(x);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        @(negedge clk);
    endtask

    task automatic run_mask(input logic [NP-1:0] m, input string tag);
        int lst[$];
        mask_list(m, lst);
        push_exp(lst, tag);
        start     = 1'b1;
        use_mask  = 1'b1;
        pass_mask = m;
        @(negedge clk);
        start     = 1'b0;
        pass_mask = '0;
        wait_idle();
    endtask

    task automatic run_stream(input int lst[$], input bit sep_last, input int gap, input string tag);
        push_exp(lst, tag);
        start    = 1'b1;
        use_mask = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < lst.size(); i++) begin
            item_valid = 1'b1;
            item_phase = PW'(lst[i]);
            item_last  = (i == lst.size() - 1) && !sep_last;
            @(negedge clk);
            item_valid = 1'b0;
            item_last  = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
        if (sep_last || lst.size() == 0) begin
            item_last = 1'b1;
            @(negedge clk);
            item_last = 1'b0;
        end
        wait_idle();
    endtask

    // Monitor: pops expected results as done pulses arrive
    logic done_d = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (err && !done) begin
                nfail++;
                $display("FAIL R8: err=%0b while done=%0b (expected err only with done)", err, done);
            end
            if (done && done_d) begin
                nfail++;
                $display("FAIL R8: done held two cycles, got done=1 expected 0");
            end
            if (done) begin
                if (sb.size() == 0) begin
                    nfail++;
                    $display("FAIL R8: unexpected done, got 1 expected 0");
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    ncomp++;
                    if (err !== x.e || (!x.e && phase !== PW'(x.ph)) || (x.e && phase !== '0)) begin
                        nfail++;
                        $display("FAIL %s: got err=%0b phase=%0d expected err=%0b phase=%0d",
                                 x.tag, err, phase, x.e, x.e ? 0 : x.ph);
                    end
                end
            end
        end
        done_d <= done;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
        $finish;
    end

    initial begin
        int l[$];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        ncomp++;
        if (done !== 1'b0 || err !== 1'b0 || busy !== 1'b0) begin
            nfail++;
            $display("FAIL R10: got done=%0b err=%0b busy=%0b expected 0 0 0", done, err, busy);
        end

        run_mask(16'h0000, "R1 empty mask");
        run_mask(16'hFFFF, "R7 all pass gives 11");
        run_mask(16'h00F0, "R6 run 4..7 gives 6");
        run_mask(16'h0200, "R6 single phase 9");
        run_mask(16'hE007, "R4 wrap join gives 0");
        run_mask(16'h071C, "R5 tie keeps earlier run");
        run_mask(16'h80E3, "R5 middle run beats equal joined window");
        run_mask(16'h8006, "R4 no join when first run misses phase 0");
        run_mask(16'h5555, "R3 alternating singles");
        run_mask(16'h8001, "R3 R4 ends join into two-phase window");

        l = {3, 4, 5, 6, 7, 12};
        run_stream(l, 1'b0, 0, "R9 stream last with entry");
        l = {0, 1, 2, 9, 10, 11, 12, 13};
        run_stream(l, 1'b1, 2, "R9 stream separate last with gaps");
        l = {};
        run_stream(l, 1'b1, 0, "R1 empty stream");
        l = {};
        for (int i = 0; i < NP; i++) l.push_back(i);
        l.push_back(15);
        run_stream(l, 1'b0, 0, "R2 seventeen entries");
        l = {};
        for (int i = 0; i < NP; i++) l.push_back(i);
        run_stream(l, 1'b0, 1, "R2 R7 exactly sixteen entries");

        // R9: entries offered while idle must not leak into the next job
        item_valid = 1'b1;
        item_phase = 4'd5;
        repeat (3) @(negedge clk);
        item_valid = 1'b0;
        l = {10, 11};
        run_stream(l, 1'b0, 0, "R9 idle entries ignored");

        for (int t = 0; t < 40; t++) begin
            logic [NP-1:0] m;
            int q[$];
            m = NP'($urandom);
            if (t % 3 == 0) m = m | 16'h8001;
            run_mask(m, "R5 R6 random mask");
            mask_list(m, q);
            run_stream(q, t[0], t % 3, "R9 random stream");
        end

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            nfail++;
            $display("FAIL R8: %0d results missing, expected 0", sb.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
        $finish;
    end

endmodule